// File: doc/BRIEF.md
# Register File with Indirect Pointer Addressing

This block holds thirty-two 8-bit working registers. Two of them can be read combinationally through independent read ports in the same clock in which a third is written. Three adjacent register pairs at the top of the file also serve as 16-bit address pointers: X (registers 27:26), Y (29:28) and Z (31:30), with the low byte in the even register. Z is also driven out on its own port so that program-memory lookups and indirect jumps can use it.

An indirect access names a pointer and an addressing mode. The block then forms the effective data address combinationally. When the mode modifies the pointer, the block writes the new value back into the register pair at the same clock edge that completes the access.

The lowest data-space addresses alias the register file. An access whose effective address falls below the register count is served from the registers themselves: a load returns the register's value on a dedicated port, and a store writes it. Every other address goes to an external data memory through an address and a strobe.

Top module: `ptr_regfile`

## Requirements
- R1: After reset every register reads as 0x00 on both read ports, and z_ptr is 0x0000.
- R2: A write-port write (wr_en=1) stores wr_data into register wr_idx at the clock edge. Both read ports return the stored value from then on.
- R3: A read port whose index is being written in the current cycle returns the value that will be stored at the coming edge (write-first bypass), not the old content.
- R4: Pointer select mem_ptr_sel encodes X=0 (r27:r26), Y=1 (r29:r28), Z=2 (r31:r30) and none=3. The low byte is in the even register. z_ptr always shows {r31,r30}.
- R5: Mode mem_mode=0 (plain): mem_addr equals the pointer, and the pointer is not modified.
- R6: Mode 1 (post-increment): mem_addr equals the pointer. The pointer becomes pointer+1 at the edge, and 0xFFFF wraps to 0x0000.
- R7: Mode 2 (pre-decrement): mem_addr equals pointer-1 in the same cycle. The pointer becomes that value at the edge, and 0x0000 wraps to 0xFFFF.
- R8: Mode 3 (displacement), legal only with Y or Z: mem_addr equals the pointer plus the unsigned 6-bit mem_disp (0 to 63), and the pointer is not modified.
- R9: An access with displacement on X, or with pointer select 3, is rejected. In that case mem_bad=1, mem_strobe=0 and reg_hit=0, and no register changes through the access.
- R10: A legal access with effective address below 0x20 sets reg_hit=1 and mem_strobe=0. A load shows that register on reg_rdata. A store (mem_store=1) writes mem_wdata into it at the edge.
- R11: A legal access with effective address 0x20 or above sets mem_strobe=1 and reg_hit=0. With mem_req=0 the outputs mem_strobe, reg_hit and mem_bad are all 0.
- R12: When several writes hit one register in one cycle, the pointer writeback wins over a register-space store, and the store wins over the write port. The read-port bypass follows the same priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Read port A data, bypassed |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Read port B data, bypassed |
| wr_en | input | 1 | Write-port enable |
| wr_idx | input | 5 | Write-port register index |
| wr_data | input | 8 | Write-port data |
| mem_req | input | 1 | Indirect access request this cycle |
| mem_ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| mem_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| mem_disp | input | 6 | Unsigned displacement for mode 3 |
| mem_store | input | 1 | 1 for a store, 0 for a load |
| mem_wdata | input | 8 | Store data used for register-space stores |
| mem_addr | output | 16 | Effective data address |
| mem_strobe | output | 1 | External data memory access this cycle |
| mem_bad | output | 1 | Access rejected as illegal |
| reg_hit | output | 1 | Access falls in register space |
| reg_rdata | output | 8 | Register content for a register-space load |
| z_ptr | output | 16 | Current Z pointer value |

## Verification
The address, strobe, reg_hit, mem_bad, reg_rdata and the two read ports are combinational in the current cycle. The bench drives each stimulus just after a falling edge and compares these outputs 5 ns later, before the next rising edge. Register contents and pointer writebacks take effect at that rising edge, one cycle after the stimulus. They are checked in the following cycle through the read ports and z_ptr, against a bench register model that is updated only at the edge. Pre-decrement is the one case where the modified pointer already appears on mem_addr in the same cycle.

// File: rtl/ptr_regfile_pkg.sv
`timescale 1ns/1ps
package ptr_regfile_pkg;
   typedef enum logic [1:0] {
      PSEL_X    = 2'd0,
      PSEL_Y    = 2'd1,
      PSEL_Z    = 2'd2,
      PSEL_NONE = 2'd3
   } psel_e;

   typedef enum logic [1:0] {
      AM_PLAIN   = 2'd0,
      AM_POSTINC = 2'd1,
      AM_PREDEC  = 2'd2,
      AM_DISP    = 2'd3
   } amode_e;
endpackage

// File: rtl/ptr_rf_store.sv
`timescale 1ns/1ps
// Register array with merged write sources; exposes next-state for bypass.
module ptr_rf_store #(
   parameter int NREG  = 32,
   parameter int DW    = 8,
   parameter int PBASE = 26
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(NREG)-1:0]       wr_idx,
   input  logic [DW-1:0]                 wr_data,
   input  logic                          st_en,
   input  logic [$clog2(NREG)-1:0]       st_idx,
   input  logic [DW-1:0]                 st_data,
   input  logic                          pw_en,
   input  logic [1:0]                    pw_sel,
   input  logic [2*DW-1:0]               pw_val,
   output logic [NREG-1:0][DW-1:0]       q,
   output logic [NREG-1:0][DW-1:0]       nxt,
   output logic [NREG-1:0]               we
);
   localparam int IW = $clog2(NREG);

   int pw_lo;
   assign pw_lo = PBASE + 2 * int'(pw_sel);

   // Lowest priority first: later assignments override earlier ones.
   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         we[i]  = 1'b0;
         nxt[i] = q[i];
         if (wr_en && (wr_idx == IW'(i))) begin
            we[i]  = 1'b1;
            nxt[i] = wr_data;
         end
         if (st_en && (st_idx == IW'(i))) begin
            we[i]  = 1'b1;
            nxt[i] = st_data;
         end
         if (pw_en && (i == pw_lo)) begin
            we[i]  = 1'b1;
            nxt[i] = pw_val[DW-1:0];
         end
         if (pw_en && (i == pw_lo + 1)) begin
            we[i]  = 1'b1;
            nxt[i] = pw_val[2*DW-1:DW];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (we[i]) q[i] <= nxt[i];
         end
      end
   end
endmodule

// File: rtl/ptr_rd_port.sv
`timescale 1ns/1ps
// One combinational read port with write-first bypass.
module ptr_rd_port #(
   parameter int NREG = 32,
   parameter int DW   = 8
) (
   input  logic [$clog2(NREG)-1:0]  idx,
   input  logic [NREG-1:0][DW-1:0]  q,
   input  logic [NREG-1:0][DW-1:0]  nxt,
   input  logic [NREG-1:0]          we,
   output logic [DW-1:0]            data
);
   assign data = we[idx] ? nxt[idx] : q[idx];
endmodule

// File: rtl/ptr_agu.sv
`timescale 1ns/1ps
// Effective-address and pointer-update generation for indirect accesses.
module ptr_agu
   import ptr_regfile_pkg::*;
#(
   parameter int DW        = 8,
   parameter int QW        = 6,
   parameter bit DISP_ON_X = 1'b0
) (
   input  logic                   req,
   input  logic [1:0]             sel,
   input  logic [1:0]             mode,
   input  logic [QW-1:0]          disp,
   input  logic [2:0][2*DW-1:0]   ptrs,
   output logic [2*DW-1:0]        addr,
   output logic                   legal,
   output logic                   bad,
   output logic                   pw_en,
   output logic [2*DW-1:0]        pw_val
);
   localparam int AW = 2 * DW;

   psel_e          s;
   amode_e         md;
   logic           x_disp_ok;
   logic [AW-1:0]  ptr;

   assign s  = psel_e'(sel);
   assign md = amode_e'(mode);

   generate
      if (DISP_ON_X) begin : g_xdisp_on
         assign x_disp_ok = 1'b1;
      end else begin : g_xdisp_off
         assign x_disp_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      case (s)
         PSEL_X:  ptr = ptrs[0];
         PSEL_Y:  ptr = ptrs[1];
         PSEL_Z:  ptr = ptrs[2];
         default: ptr = '0;
      endcase
   end

   assign legal = req && (s != PSEL_NONE)
                  && !((md == AM_DISP) && (s == PSEL_X) && !x_disp_ok);
   assign bad   = req && !legal;
   assign pw_en = legal && ((md == AM_POSTINC) || (md == AM_PREDEC));

   always_comb begin
      pw_val = ptr;
      case (md)
         AM_PLAIN:   addr = ptr;
         AM_POSTINC: begin
            addr   = ptr;
            pw_val = ptr + AW'(1);
         end
         AM_PREDEC:  begin
            addr   = ptr - AW'(1);
            pw_val = ptr - AW'(1);
         end
         default:    addr = ptr + AW'(disp);
      endcase
   end
endmodule

// File: rtl/ptr_regfile.sv
`timescale 1ns/1ps
// Register file whose top pairs double as 16-bit indirect pointers.
module ptr_regfile #(
   parameter int NREG      = 32,
   parameter int DW        = 8,
   parameter int QW        = 6,
   parameter int PBASE     = 26,
   parameter bit DISP_ON_X = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(NREG)-1:0]   rd_a_idx,
   output logic [DW-1:0]             rd_a_data,
   input  logic [$clog2(NREG)-1:0]   rd_b_idx,
   output logic [DW-1:0]             rd_b_data,
   input  logic                      wr_en,
   input  logic [$clog2(NREG)-1:0]   wr_idx,
   input  logic [DW-1:0]             wr_data,
   input  logic                      mem_req,
   input  logic [1:0]                mem_ptr_sel,
   input  logic [1:0]                mem_mode,
   input  logic [QW-1:0]             mem_disp,
   input  logic                      mem_store,
   input  logic [DW-1:0]             mem_wdata,
   output logic [2*DW-1:0]           mem_addr,
   output logic                      mem_strobe,
   output logic                      mem_bad,
   output logic                      reg_hit,
   output logic [DW-1:0]             reg_rdata,
   output logic [2*DW-1:0]           z_ptr
);
   localparam int AW     = 2 * DW;
   localparam int IW     = $clog2(NREG);
   localparam int NPTR   = 3;
   localparam int NRPORT = 2;

   initial begin
      assert (PBASE + 2 * NPTR <= NREG) else $error("pointer pairs exceed register count");
      assert (NREG == (1 << IW))        else $error("register count must be a power of two");
      assert (QW < AW)                  else $error("displacement wider than address");
   end

   logic [NREG-1:0][DW-1:0]  q, nxt;
   logic [NREG-1:0]          we;
   logic [NPTR-1:0][AW-1:0]  ptr_val;
   logic                     legal, pw_en, st_en;
   logic [AW-1:0]            pw_val;
   logic [IW-1:0]            ea_idx;

   generate
      for (genvar k = 0; k < NPTR; k++) begin : g_ptr
         assign ptr_val[k] = {q[PBASE + 2*k + 1], q[PBASE + 2*k]};
      end
   endgenerate

   ptr_agu #(.DW(DW), .QW(QW), .DISP_ON_X(DISP_ON_X)) u_agu (
      .req    (mem_req),
      .sel    (mem_ptr_sel),
      .mode   (mem_mode),
      .disp   (mem_disp),
      .ptrs   (ptr_val),
      .addr   (mem_addr),
      .legal  (legal),
      .bad    (mem_bad),
      .pw_en  (pw_en),
      .pw_val (pw_val)
   );

   assign reg_hit    = legal && (mem_addr < AW'(NREG));
   assign mem_strobe = legal && !reg_hit;
   assign ea_idx     = mem_addr[IW-1:0];
   assign st_en      = reg_hit && mem_store;
   assign reg_rdata  = reg_hit ? q[ea_idx] : '0;
   assign z_ptr      = ptr_val[2];

   ptr_rf_store #(.NREG(NREG), .DW(DW), .PBASE(PBASE)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .st_en   (st_en),
      .st_idx  (ea_idx),
      .st_data (mem_wdata),
      .pw_en   (pw_en),
      .pw_sel  (mem_ptr_sel),
      .pw_val  (pw_val),
      .q       (q),
      .nxt     (nxt),
      .we      (we)
   );

   logic [NRPORT-1:0][IW-1:0] rp_idx;
   logic [NRPORT-1:0][DW-1:0] rp_dat;
   assign rp_idx = {rd_b_idx, rd_a_idx};

   generate
      for (genvar p = 0; p < NRPORT; p++) begin : g_rport
         ptr_rd_port #(.NREG(NREG), .DW(DW)) u_rp (
            .idx  (rp_idx[p]),
            .q    (q),
            .nxt  (nxt),
            .we   (we),
            .data (rp_dat[p])
         );
      end
   endgenerate

   assign rd_a_data = rp_dat[0];
   assign rd_b_data = rp_dat[1];
endmodule

// File: rtl/ptr_regfile_chk.sv
`timescale 1ns/1ps
module ptr_regfile_chk #(
   parameter int AW        = 16,
   parameter bit DISP_ON_X = 1'b0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mem_req,
   input logic [1:0]          mem_ptr_sel,
   input logic [1:0]          mem_mode,
   input logic                wr_en,
   input logic [AW-1:0]       mem_addr,
   input logic                mem_strobe,
   input logic                mem_bad,
   input logic                reg_hit,
   input logic [2:0][AW-1:0]  ptr_val
);
   AST_HIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_strobe && reg_hit)); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (!mem_strobe && !reg_hit && !mem_bad)); // R11

   AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ptr_sel != 2'd3 && mem_mode == 2'd2)
      |-> (mem_addr == ptr_val[mem_ptr_sel] - AW'(1))); // R7

   AST_POSTINC_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ptr_sel != 2'd3 && mem_mode == 2'd1)
      |=> (ptr_val[$past(mem_ptr_sel)] == $past(mem_addr) + AW'(1))); // R6

   AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ptr_sel != 2'd3 && mem_mode == 2'd3 && !wr_en && !reg_hit)
      |=> (ptr_val[$past(mem_ptr_sel)] == $past(ptr_val[mem_ptr_sel]))); // R8

   AST_X_DISP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!DISP_ON_X && mem_req && mem_ptr_sel == 2'd0 && mem_mode == 2'd3)
      |-> (mem_bad && !mem_strobe && !reg_hit)); // R9
endmodule

bind ptr_regfile ptr_regfile_chk #(.AW(2*DW), .DISP_ON_X(DISP_ON_X)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_ptr_sel (mem_ptr_sel),
   .mem_mode    (mem_mode),
   .wr_en       (wr_en),
   .mem_addr    (mem_addr),
   .mem_strobe  (mem_strobe),
   .mem_bad     (mem_bad),
   .reg_hit     (reg_hit),
   .ptr_val     (ptr_val)
);

// File: tb/tb_ptr_regfile.sv
`timescale 1ns/1ps
module tb_ptr_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
   logic [7:0]  rd_a_data, rd_b_data, wr_data, mem_wdata, reg_rdata;
   logic        wr_en, mem_req, mem_store, mem_strobe, mem_bad, reg_hit;
   logic [1:0]  mem_ptr_sel, mem_mode;
   logic [5:0]  mem_disp;
   logic [15:0] mem_addr, z_ptr;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [7:0] m  [32];
   logic [7:0] nm [32];
   int         nw [32];

   always #10 clk = ~clk;

   ptr_regfile dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .mem_req(mem_req), .mem_ptr_sel(mem_ptr_sel), .mem_mode(mem_mode),
      .mem_disp(mem_disp), .mem_store(mem_store), .mem_wdata(mem_wdata),
      .mem_addr(mem_addr), .mem_strobe(mem_strobe), .mem_bad(mem_bad),
      .reg_hit(reg_hit), .reg_rdata(reg_rdata), .z_ptr(z_ptr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mptr(input int s);
      return {m[26 + 2*s + 1], m[26 + 2*s]};
   endfunction

   task automatic idle();
      wr_en = 0; wr_idx = 0; wr_data = 0;
      mem_req = 0; mem_ptr_sel = 0; mem_mode = 0; mem_disp = 0;
      mem_store = 0; mem_wdata = 0;
      rd_a_idx = 0; rd_b_idx = 0;
   endtask

   function automatic string rtag(input int i);
      if (nw[i] > 1) return "R12";
      if (nw[i] == 1) return "R3";
      return "R2";
   endfunction

   // Compare combinational outputs mid-cycle, then commit the model at the edge.
   task automatic step();
      bit legal, hit, ptrw;
      logic [15:0] p, ea, np;
      int s, md;
      #5;
      s  = int'(mem_ptr_sel);
      md = int'(mem_mode);
      p  = (s == 3) ? 16'h0 : mptr(s);
      legal = mem_req && s != 3 && !(md == 3 && s == 0);
      ptrw = 0; np = p;
      case (md)
         0: ea = p;
         1: begin ea = p; np = p + 16'd1; ptrw = legal; end
         2: begin ea = p - 16'd1; np = ea; ptrw = legal; end
         default: ea = p + {10'd0, mem_disp};
      endcase
      hit = legal && (ea < 16'd32);
      for (int i = 0; i < 32; i++) begin nm[i] = m[i]; nw[i] = 0; end
      if (wr_en) begin nm[wr_idx] = wr_data; nw[wr_idx]++; end
      if (hit && mem_store) begin nm[ea[4:0]] = mem_wdata; nw[ea[4:0]]++; end
      if (ptrw) begin
         nm[26 + 2*s] = np[7:0];      nw[26 + 2*s]++;
         nm[26 + 2*s + 1] = np[15:8]; nw[26 + 2*s + 1]++;
      end
      chk(rd_a_data == nm[rd_a_idx], rtag(rd_a_idx), "read A", rd_a_data, nm[rd_a_idx]);
      chk(rd_b_data == nm[rd_b_idx], rtag(rd_b_idx), "read B", rd_b_data, nm[rd_b_idx]);
      chk(z_ptr == mptr(2), "R4", "z_ptr", z_ptr, mptr(2));
      chk(mem_bad == (mem_req && !legal), "R9", "mem_bad", mem_bad, mem_req && !legal);
      chk(reg_hit == hit, "R10", "reg_hit", reg_hit, hit);
      chk(mem_strobe == (legal && !hit), "R11", "mem_strobe", mem_strobe, legal && !hit);
      if (legal) begin
         case (md)
            0: chk(mem_addr == ea, "R5", "addr plain", mem_addr, ea);
            1: chk(mem_addr == ea, "R6", "addr postinc", mem_addr, ea);
            2: chk(mem_addr == ea, "R7", "addr predec", mem_addr, ea);
            default: chk(mem_addr == ea, "R8", "addr disp", mem_addr, ea);
         endcase
      end
      if (hit && !mem_store)
         chk(reg_rdata == m[ea[4:0]], "R10", "reg_rdata", reg_rdata, m[ea[4:0]]);
      @(posedge clk);
      for (int i = 0; i < 32; i++) m[i] = nm[i];
      @(negedge clk);
   endtask

   task automatic wr(input int idx, input int val);
      idle(); wr_en = 1; wr_idx = 5'(idx); wr_data = 8'(val);
      step();
   endtask

   task automatic set_ptr(input int s, input int val);
      wr(26 + 2*s, val & 8'hFF);
      wr(27 + 2*s, (val >> 8) & 8'hFF);
   endtask

   task automatic op(input int s, input int md, input int d, input bit st, input int wd);
      idle();
      mem_req = 1; mem_ptr_sel = 2'(s); mem_mode = 2'(md);
      mem_disp = 6'(d); mem_store = st; mem_wdata = 8'(wd);
      step();
   endtask

   task automatic expect_ptr(input int s, input int val, input string tag);
      idle();
      rd_a_idx = 5'(26 + 2*s); rd_b_idx = 5'(27 + 2*s);
      #5;
      chk({rd_b_data, rd_a_data} == 16'(val), tag, "pointer value",
          {rd_b_data, rd_a_data}, val);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      idle();
      for (int i = 0; i < 32; i++) m[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents through both read ports
      for (int i = 0; i < 16; i++) begin
         idle(); rd_a_idx = 5'(2*i); rd_b_idx = 5'(2*i + 1);
         #5;
         chk(rd_a_data == 8'h00 && rd_b_data == 8'h00, "R1", "reset regs",
             {rd_b_data, rd_a_data}, 0);
         if (i == 0) chk(z_ptr == 16'h0000, "R1", "reset z_ptr", z_ptr, 0);
         @(negedge clk);
      end

      // R6: post-increment wraps at the top
      set_ptr(0, 16'hFFFF);
      op(0, 1, 0, 0, 0);
      expect_ptr(0, 16'h0000, "R6");

      // R7: pre-decrement wraps at zero
      set_ptr(1, 16'h0000);
      op(1, 2, 0, 0, 0);
      expect_ptr(1, 16'hFFFF, "R7");

      // R5 / R4: plain access through Z
      set_ptr(2, 16'h1234);
      op(2, 0, 0, 0, 0);
      expect_ptr(2, 16'h1234, "R5");

      // R8: displacement upper bound and register-space hit
      set_ptr(2, 16'h0010);
      op(2, 3, 63, 0, 0);
      wr(21, 8'hC3);
      op(2, 3, 5, 0, 0);
      expect_ptr(2, 16'h0010, "R8");

      // R9: illegal combinations
      set_ptr(0, 16'h0040);
      op(0, 3, 7, 1, 8'hEE);
      op(3, 1, 0, 1, 8'hEE);
      expect_ptr(0, 16'h0040, "R9");

      // R12: X points at its own low byte; writeback beats store and write port
      set_ptr(0, 16'h001A);
      idle();
      mem_req = 1; mem_ptr_sel = 0; mem_mode = 1; mem_store = 1; mem_wdata = 8'h55;
      wr_en = 1; wr_idx = 5'd27; wr_data = 8'h99;
      rd_a_idx = 5'd26; rd_b_idx = 5'd27;
      step();
      expect_ptr(0, 16'h001B, "R12");

      // R12 / R3: store beats write port, bypass on read
      set_ptr(2, 16'h0003);
      idle();
      mem_req = 1; mem_ptr_sel = 2; mem_mode = 0; mem_store = 1; mem_wdata = 8'h3C;
      wr_en = 1; wr_idx = 5'd3; wr_data = 8'h77; rd_a_idx = 5'd3;
      step();
      idle(); wr_en = 1; wr_idx = 5'd5; wr_data = 8'hA5; rd_a_idx = 5'd5; rd_b_idx = 5'd3;
      step();

      // Random mix
      for (int n = 0; n < 4000; n++) begin
         idle();
         wr_en = 1'($urandom % 2);
         wr_idx = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom % 32);
         case ($urandom % 3)
            0: wr_data = 8'h00;
            1: wr_data = 8'($urandom % 64);
            default: wr_data = 8'($urandom);
         endcase
         mem_req = 1'($urandom % 4 != 0);
         mem_ptr_sel = 2'($urandom);
         mem_mode = 2'($urandom);
         mem_disp = 6'($urandom);
         mem_store = 1'($urandom);
         mem_wdata = 8'($urandom);
         rd_a_idx = 5'($urandom);
         rd_b_idx = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
         step();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule